// File: doc/BRIEF.md
# LPC memory target cycle controller

This block is the target side of a Low Pin Count memory bus. It watches an active-low frame strobe and a 4-bit multiplexed address/data bus and recognises a memory cycle by its start nibble. It then decodes the cycle direction and gathers a 32-bit address over eight nibbles. A write then takes one data byte from the host. A read hands the bus over, signals ready with a sync nibble, returns one byte and hands the bus back. A small byte store sits behind an internal request port and holds the data. An active-low chip-select input enables the target. The host can cancel a cycle at any time by pulling the frame strobe low again. The target then waits until it sees an all-ones nibble.

The bus is split into `lad_in` (what the target samples) and `lad_out`/`lad_oe` (what the target drives). The pad level merges these into a tri-state pin. Only memory read and memory write cycles of a single byte are handled.

Top module: `lpc_mem_target`

## Requirements
- R1: After synchronous reset (`rst_n` low at a rising edge) the target is ready for a new cycle and `lad_oe` is low.
- R2: While in ready state, `lad_in` is sampled at every rising edge where `frame_n` is low. At the first edge where `frame_n` is high again, the last sampled value is the start nibble. Only 4'b0000 starts a cycle, and any other value leaves the target ready.
- R3: A cycle is accepted only if `sel_n` was low at the rising edge just before the last edge at which `frame_n` was low. Otherwise the cycle is ignored.
- R4: The nibble sampled at the first high-frame edge after a start gives the direction. Bits [3:1] = 3'b010 mean memory read and 3'b011 mean memory write, and bit 0 is don't-care. Any other value leaves the target ready.
- R5: The eight nibbles after the direction nibble form the address, most significant nibble first. The byte location used is the low `MEM_AW` bits of that address.
- R6: On a write, the two nibbles after the address are the data byte, low nibble first. The byte is stored and then two turnaround clocks follow, during which `lad_oe` stays low for the whole cycle.
- R7: On a read, the clock periods after the last address edge are: two turnaround clocks with `lad_oe` low, one sync clock driving 4'b0000, the low data nibble, the high data nibble, one clock driving 4'b1111, and one clock with `lad_oe` low. The target is then ready again.
- R8: If `frame_n` is low at any edge after a cycle has started, the target drops the cycle and stores nothing. It then waits with `lad_oe` low and ignores all input until a rising edge samples `lad_in` = 4'b1111, after which it is ready again.
- R9: `lad_oe` is high only during the sync clock, the data clocks and the first closing turnaround clock of a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame strobe from the host, active low |
| sel_n | input | 1 | Chip select, active low |
| lad_in | input | 4 | Sampled value of the multiplexed bus |
| lad_out | output | 4 | Value the target drives onto the bus |
| lad_oe | output | 1 | Target owns and drives the bus |

## Verification
The bench holds the frame strobe low for several clocks while the start nibble changes, in both orders. A design that latched the first nibble instead of the last would store a byte it should ignore, or ignore one it should store. It moves chip select by one clock around the start cycle, which exposes a design that samples select on the wrong edge. Byte values with distinct nibbles and addresses whose nibble-reversed form is also in use catch wrong nibble order on the address or data path. An abort in the middle of the address phase is followed by a complete well-formed write. A design that left the wait state on anything but all ones, or that finished the cut cycle, would overwrite the byte that is read back afterwards.

// File: rtl/lpc_tgt_pkg.sv
// Shared types and constants for the LPC memory target.
// Assumes a 4-bit multiplexed bus; all other widths are parameters of the modules.
package lpc_tgt_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_TAR_IN,
        ST_SYNC,
        ST_RDATA,
        ST_TAR_OUT,
        ST_ABORT
    } tgt_state_e;

    localparam logic [NIB_W-1:0] NIB_START  = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_ABORT  = 4'b1111;
    localparam logic [NIB_W-1:0] NIB_SYNC   = 4'b0000;
    localparam logic [NIB_W-1:0] NIB_RELEASE = 4'b1111;
    localparam logic [2:0]       DIR_READ   = 3'b010;
    localparam logic [2:0]       DIR_WRITE  = 3'b011;

endpackage

// File: rtl/lpc_start_detect.sv
// Start-nibble detector.
// While armed, it latches the bus on every edge with the frame strobe low and
// records whether chip select was active one edge earlier. It reports a valid
// start on the first high-frame edge if the last latched nibble was all zeros
// and the target was selected. Assumes the parent arms it only when ready.
module lpc_start_detect
    import lpc_tgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             frame_n,
    input  logic             sel_n,
    input  logic [NIB_W-1:0] lad_in,
    output logic             start_fire
);

    logic             framing_q;
    logic [NIB_W-1:0] start_q;
    logic             sel_prev_q;
    logic             ce_ok_q;

    // Remember chip select from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev_q <= 1'b0;
        else        sel_prev_q <= !sel_n;
    end

    // Track the frame-low stretch and keep the last nibble and select seen in it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            framing_q <= 1'b0;
            start_q   <= NIB_ABORT;
            ce_ok_q   <= 1'b0;
        end else if (!armed) begin
            framing_q <= 1'b0;
        end else begin
            framing_q <= !frame_n;
            if (!frame_n) begin
                start_q <= lad_in;
                ce_ok_q <= sel_prev_q;
            end
        end
    end

    // A start is valid at the edge where the frame strobe has just gone high.
    always_comb begin
        start_fire = armed && frame_n && framing_q && ce_ok_q && (start_q == NIB_START);
    end

endmodule

// File: rtl/lpc_byte_store.sv
// Byte-wide storage behind a single request port.
// A write request stores the byte at the next edge. A read request loads the
// output register at the next edge, which then holds until the next read.
// Assumes one request at most per clock.
module lpc_byte_store #(
    parameter int MEM_AW = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [MEM_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte on a write request.
    always_ff @(posedge clk) begin
        if (req && we) mem[addr] <= wdata;
    end

    // Load the read register on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata <= '0;
        else if (req && !we)  rdata <= mem[addr];
    end

endmodule

// File: rtl/lpc_bus_drive.sv
// Output stage: chooses what the target drives on the bus and when.
// It drives sync and data during a read, then the release nibble for one
// clock, and leaves the bus undriven otherwise. Assumes data nibbles go out
// low nibble first, counted by the parent's phase counter.
module lpc_bus_drive
    import lpc_tgt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  tgt_state_e        state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              is_read,
    input  logic [DATA_W-1:0] rdata,
    output logic [NIB_W-1:0]  lad_out,
    output logic              lad_oe
);

    logic [DATA_W-1:0] shifted;

    // Pick the data nibble selected by the counter.
    always_comb begin
        shifted = rdata >> (int'(cnt) * NIB_W);
    end

    // Decide ownership of the bus and the value driven.
    always_comb begin
        lad_out = '0;
        lad_oe  = 1'b0;
        case (state)
            ST_SYNC: begin
                lad_out = NIB_SYNC;
                lad_oe  = 1'b1;
            end
            ST_RDATA: begin
                lad_out = shifted[NIB_W-1:0];
                lad_oe  = 1'b1;
            end
            ST_TAR_OUT: begin
                if (is_read && (cnt == '0)) begin
                    lad_out = NIB_RELEASE;
                    lad_oe  = 1'b1;
                end
            end
            default: begin
                lad_out = '0;
                lad_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_mem_target.sv
// LPC memory target cycle controller (top).
// It sequences a single-byte memory read or write: start detection, direction,
// eight address nibbles, then a data phase for writes, or turnaround, sync and
// data for reads, and closes every cycle with a two-clock turnaround. A frame
// strobe seen low mid-cycle drops the cycle into an abort wait that only an
// all-ones nibble clears. Assumes MEM_AW and DATA_W are multiples of 4 and
// greater than 4, and that ADDR_W/4 >= DATA_W/4.
module lpc_mem_target
    import lpc_tgt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 8,
    parameter int MEM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             sel_n,
    input  logic [3:0]       lad_in,
    output logic [3:0]       lad_out,
    output logic             lad_oe
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int TAR_LEN   = 2;
    localparam int CNT_W     = $clog2(ADDR_NIBS);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);
    localparam logic [CNT_W-1:0] TAR_LAST  = CNT_W'(TAR_LEN - 1);

    tgt_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              is_read_q;
    logic [MEM_AW-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              mem_req_q;
    logic              mem_we_q;
    logic [DATA_W-1:0] rdata;
    logic              start_fire;
    logic              armed;
    logic              in_cycle;

    // The detector listens only while the target is ready.
    always_comb begin
        armed    = (state_q == ST_IDLE);
        in_cycle = (state_q != ST_IDLE) && (state_q != ST_ABORT);
    end

    lpc_start_detect i_start (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .frame_n    (frame_n),
        .sel_n      (sel_n),
        .lad_in     (lad_in),
        .start_fire (start_fire)
    );

    // Cycle sequencer: phase state, phase counter, address and write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            is_read_q <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            mem_req_q <= 1'b0;
            mem_we_q  <= 1'b0;
        end else begin
            mem_req_q <= 1'b0;
            mem_we_q  <= 1'b0;
            if (in_cycle && !frame_n) begin
                state_q <= ST_ABORT;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        if (start_fire) begin
                            if (lad_in[3:1] == DIR_READ) begin
                                is_read_q <= 1'b1;
                                state_q   <= ST_ADDR;
                            end else if (lad_in[3:1] == DIR_WRITE) begin
                                is_read_q <= 1'b0;
                                state_q   <= ST_ADDR;
                            end
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= {addr_q[MEM_AW-NIB_W-1:0], lad_in};
                        if (cnt_q == ADDR_LAST) begin
                            cnt_q <= '0;
                            if (is_read_q) begin
                                state_q   <= ST_TAR_IN;
                                mem_req_q <= 1'b1;
                            end else begin
                                state_q <= ST_WDATA;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        wdata_q <= {lad_in, wdata_q[DATA_W-1:NIB_W]};
                        if (cnt_q == DATA_LAST) begin
                            cnt_q     <= '0;
                            state_q   <= ST_TAR_OUT;
                            mem_req_q <= 1'b1;
                            mem_we_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_TAR_IN: begin
                        if (cnt_q == TAR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_SYNC;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_SYNC: begin
                        cnt_q   <= '0;
                        state_q <= ST_RDATA;
                    end
                    ST_RDATA: begin
                        if (cnt_q == DATA_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_TAR_OUT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_TAR_OUT: begin
                        if (cnt_q == TAR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_ABORT: begin
                        cnt_q <= '0;
                        if (lad_in == NIB_ABORT) state_q <= ST_IDLE;
                    end
                    default: begin
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    lpc_byte_store #(
        .MEM_AW (MEM_AW),
        .DATA_W (DATA_W)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (mem_req_q),
        .we    (mem_we_q),
        .addr  (addr_q),
        .wdata (wdata_q),
        .rdata (rdata)
    );

    lpc_bus_drive #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_drive (
        .state   (state_q),
        .cnt     (cnt_q),
        .is_read (is_read_q),
        .rdata   (rdata),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

endmodule

// File: rtl/lpc_mem_target_chk.sv
// Protocol checker for the LPC memory target, attached by bind.
// Assumes it sees the sequencer state and the internal store request.
module lpc_mem_target_chk
    import lpc_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_in,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input tgt_state_e state,
    input logic       mem_req,
    input logic       mem_we
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !lad_oe);

    assert_store_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(state) == ST_WDATA));

    assert_tar_in_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAR_IN) |-> !lad_oe);

    assert_sync_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> (lad_oe && (lad_out == 4'b0000)));

    assert_release_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TAR_OUT) && ($past(state) == ST_TAR_OUT)) |-> !lad_oe);

    assert_abort_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && (state != ST_ABORT) && !frame_n) |=> (state == ST_ABORT));

    assert_abort_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ABORT) && (lad_in != 4'b1111)) |=> (state == ST_ABORT));

    assert_abort_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ABORT) && (lad_in == 4'b1111)) |=> (state == ST_IDLE));

    assert_drive_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lad_oe |-> ((state == ST_SYNC) || (state == ST_RDATA) || (state == ST_TAR_OUT)));

endmodule

bind lpc_mem_target lpc_mem_target_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .lad_in  (lad_in),
    .lad_out (lad_out),
    .lad_oe  (lad_oe),
    .state   (state_q),
    .mem_req (mem_req_q),
    .mem_we  (mem_we_q)
);

// File: tb/test_lpc_mem_target.sv
// Directed bench for the LPC memory target: one task per scenario.
module test_lpc_mem_target;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic       sel_n = 1'b0;
    logic [3:0] lad_in = 4'h0;
    logic [3:0] lad_out;
    logic       lad_oe;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lpc_mem_target i_lpc_mem_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .sel_n   (sel_n),
        .lad_in  (lad_in),
        .lad_out (lad_out),
        .lad_oe  (lad_oe)
    );

    // One bus clock: the edge, then sample point at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic f, input logic [3:0] d);
        frame_n = f;
        lad_in  = d;
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Direction, address and data of a write; the bus must stay undriven.
    task automatic write_body(input logic [31:0] addr, input logic [7:0] data, input string req);
        put(1'b1, 4'b0110); step();
        chk(req, "oe after direction", {7'd0, lad_oe}, 8'd0);
        for (int i = 7; i >= 0; i--) begin
            put(1'b1, addr[i*4 +: 4]); step();
            chk(req, "oe in address", {7'd0, lad_oe}, 8'd0);
        end
        put(1'b1, data[3:0]); step();
        chk(req, "oe in data lo", {7'd0, lad_oe}, 8'd0);
        put(1'b1, data[7:4]); step();
        chk(req, "oe in data hi", {7'd0, lad_oe}, 8'd0);
        put(1'b1, 4'h0); step();
        chk(req, "oe in turnaround", {7'd0, lad_oe}, 8'd0);
        step();
        chk(req, "oe after cycle", {7'd0, lad_oe}, 8'd0);
    endtask

    task automatic write_cycle(input logic [31:0] addr, input logic [7:0] data);
        put(1'b0, 4'h0); step();
        write_body(addr, data, "R6");
    endtask

    // Complete read with per-clock checks of the returned nibbles.
    task automatic read_cycle(input logic [3:0] dir, input logic [31:0] addr, input logic [7:0] exp, input string req);
        put(1'b0, 4'h0); step();
        put(1'b1, dir); step();
        for (int i = 7; i >= 0; i--) begin
            put(1'b1, addr[i*4 +: 4]); step();
        end
        put(1'b1, 4'h0);
        chk("R7", "oe turnaround 1", {7'd0, lad_oe}, 8'd0);
        step();
        chk("R7", "oe turnaround 2", {7'd0, lad_oe}, 8'd0);
        step();
        chk("R7", "sync oe+value", {3'd0, lad_oe, lad_out}, 8'h10);
        step();
        chk(req, "data lo nibble", {3'd0, lad_oe, lad_out}, {4'h1, exp[3:0]});
        step();
        chk(req, "data hi nibble", {3'd0, lad_oe, lad_out}, {4'h1, exp[7:4]});
        step();
        chk("R9", "release nibble", {3'd0, lad_oe, lad_out}, 8'h1F);
        step();
        chk("R7", "oe after release", {7'd0, lad_oe}, 8'd0);
        step();
        chk("R7", "oe back in ready", {7'd0, lad_oe}, 8'd0);
    endtask

    task automatic t_reset();
        chk("R1", "oe after reset", {7'd0, lad_oe}, 8'd0);
        step();
        chk("R1", "oe idle", {7'd0, lad_oe}, 8'd0);
    endtask

    task automatic t_write_read();
        write_cycle(32'hFFFF_FF12, 8'hA5);
        write_cycle(32'h0000_0021, 8'h3B);
        read_cycle(4'b0100, 32'hFFFF_FF12, 8'hA5, "R5");
        read_cycle(4'b0101, 32'hFFFF_FF21, 8'h3B, "R4");
        read_cycle(4'b0100, 32'h0000_0012, 8'hA5, "R6");
    endtask

    task automatic t_long_start();
        put(1'b0, 4'h5); step();
        put(1'b0, 4'h0); step();
        write_body(32'h0000_0034, 8'h3C, "R2");
        read_cycle(4'b0100, 32'h0000_0034, 8'h3C, "R2");
        put(1'b0, 4'h0); step();
        put(1'b0, 4'h5); step();
        write_body(32'h0000_0034, 8'h77, "R2");
        read_cycle(4'b0100, 32'h0000_0034, 8'h3C, "R2");
    endtask

    task automatic t_bad_start();
        put(1'b0, 4'h2); step();
        write_body(32'h0000_0034, 8'h99, "R2");
        read_cycle(4'b0100, 32'h0000_0034, 8'h3C, "R2");
    endtask

    task automatic t_chip_enable();
        sel_n = 1'b1; put(1'b1, 4'h0); step();
        sel_n = 1'b0; put(1'b0, 4'h0); step();
        write_body(32'h0000_0034, 8'h44, "R3");
        read_cycle(4'b0100, 32'h0000_0034, 8'h3C, "R3");
        sel_n = 1'b0; put(1'b1, 4'h0); step();
        sel_n = 1'b1; put(1'b0, 4'h0); step();
        sel_n = 1'b0;
        write_body(32'h0000_0034, 8'h66, "R3");
        read_cycle(4'b0100, 32'h0000_0034, 8'h66, "R3");
    endtask

    task automatic t_bad_dir();
        put(1'b0, 4'h0); step();
        put(1'b1, 4'b0000); step();
        for (int i = 0; i < 16; i++) begin
            put(1'b1, 4'h0); step();
            chk("R4", "oe for non-memory cycle", {7'd0, lad_oe}, 8'd0);
        end
    endtask

    task automatic t_abort();
        write_cycle(32'h0000_0056, 8'hC3);
        put(1'b0, 4'h0); step();
        put(1'b1, 4'b0110); step();
        for (int i = 0; i < 3; i++) begin
            put(1'b1, 4'h0); step();
        end
        put(1'b0, 4'hF); step();
        chk("R8", "oe on abort", {7'd0, lad_oe}, 8'd0);
        put(1'b0, 4'h0); step();
        write_body(32'h0000_0056, 8'h12, "R8");
        put(1'b1, 4'hF); step();
        read_cycle(4'b0100, 32'h0000_0056, 8'hC3, "R8");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_long_start();
        t_bad_start();
        t_chip_enable();
        t_bad_dir();
        t_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule